// File: doc/BRIEF.md
# Reset Configuration Sampler and Breakpoint Router

This block fixes two configuration choices while the system is held in reset, then acts on breakpoint requests once reset is gone. A shared pad is read for as long as reset is asserted. Its level at the last reset cycle selects the clock source: high means the on-chip synthesizer makes the clock from a reference frequency, low means the synthesizer is off and an outside system clock drives the chip. Two active-low breakpoint lines, one from inside the chip and one from a pad, are read as reset ends. If either line is low at that moment, a debug-mode flag is set. Both decisions then hold until the next reset.

After reset, the two breakpoint lines pass through a synchronizer and are ANDed. A falling edge of that combined level raises a one-cycle request. The debug-mode flag picks the output: debug-mode entry when set, breakpoint exception when clear. The shared pad then serves as bit 0 of a general-purpose port. The bit has a data latch and a direction latch that are written through a small register interface. Out of reset the bit is an input, and its output driver is held off for the whole of reset so the block cannot alter its own clock-mode sample.

Top module: `boot_cfg_bkpt`

## Requirements
- R1: `synth_en_o` equals the level of `mode_pin_i` sampled at the last rising clock edge with `rst_n` low (1 = synthesizer from reference, 0 = external clock).
- R2: Once `rst_n` is high, `synth_en_o` and `dbg_mode_o` keep their values whatever `mode_pin_i` and `bkpt_n_i` do, until reset is asserted again.
- R3: `dbg_mode_o` is 1 after reset if either bit of `bkpt_n_i` (bit 0 internal, bit 1 external, both active low) was 0 for at least two cycles before reset release.
- R4: `dbg_mode_o` is 0 after reset if both bits of `bkpt_n_i` were 1 for at least two cycles before reset release.
- R5: When the AND of both `bkpt_n_i` bits is first sampled 0 at edge k (after being 1 at edge k-1), a request is high for exactly the one cycle that follows edge k+2.
- R6: A request goes only to `dbg_req_o` when `dbg_mode_o` is 1, and only to `exc_req_o` when it is 0. The two are never high together.
- R7: No request is raised while `rst_n` is low, while the combined line stays low (including a second line falling while the first is already low), or on leaving reset with a line already low.
- R8: Port writes use `wr_sel_i` = 0 for the data latch and 1 for the direction latch (1 = output). Reset clears both latches. `mode_pin_o` drives the data latch.
- R9: With `rd_sel_i` = 0, `rd_data_o` returns `mode_pin_i` when the direction latch is 0 and the data latch when it is 1. With `rd_sel_i` = 1, it returns the direction latch.
- R10: `mode_pin_oe_o` is 0 at any time `rst_n` is low, including before the next clock edge. Out of reset it equals the direction latch.
- R11: Writes presented while `rst_n` is low change neither latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the configuration sampling window |
| mode_pin_i | input | 1 | Level of the shared clock-mode / port pad |
| mode_pin_o | output | 1 | Value driven onto the shared pad |
| mode_pin_oe_o | output | 1 | Output enable of the shared pad |
| bkpt_n_i | input | 2 | Active-low breakpoint lines: bit 0 internal, bit 1 external |
| wr_en_i | input | 1 | Port register write strobe |
| wr_sel_i | input | 1 | Write target: 0 data, 1 direction |
| wr_data_i | input | 1 | Write value |
| rd_sel_i | input | 1 | Read source: 0 port bit, 1 direction |
| rd_data_o | output | 1 | Read value |
| synth_en_o | output | 1 | Sampled clock mode: 1 synthesizer, 0 external clock |
| dbg_mode_o | output | 1 | Debug-mode flag fixed at reset release |
| dbg_req_o | output | 1 | One-cycle request to enter debug mode |
| exc_req_o | output | 1 | One-cycle request for breakpoint exception processing |

## Verification
Several properties are checked on every cycle: the latched configuration holds steady outside reset, requests are single-cycle and mutually exclusive, each request agrees with the debug flag and follows an internal falling-edge event, and the output driver stays off in reset and turns on after a direction write. Other behaviour can only be shown by the bench's scenarios and its per-cycle reference model. These cover which sampled level becomes the configuration, the exact edge on which a request appears, the absence of a pulse when a line is already low at release, the immediate driver cut-off as reset asserts, and writes that are dropped during reset.

// File: rtl/boot_cfg_bkpt_pkg.sv
package boot_cfg_bkpt_pkg;

  typedef enum logic {
    PSEL_DATA = 1'b0,
    PSEL_DIR  = 1'b1
  } port_sel_e;

  // Debug flag from the combined (ANDed, active-low) breakpoint level.
  function automatic logic dbg_from_combined(input logic all_high);
    return !all_high;
  endfunction

  // {debug request, exception request} for a falling-edge event.
  function automatic logic [1:0] route_req(input logic fall, input logic dbg);
    return {fall & dbg, fall & !dbg};
  endfunction

  // Value seen when the port bit is read.
  function automatic logic port_read(input logic dir, input logic dq,
                                     input logic pad);
    return dir ? dq : pad;
  endfunction

endpackage

// File: rtl/boot_cfg_bkpt_sync.sv
module boot_cfg_bkpt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // Free-running so the chain is settled by the time reset is released.
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk) begin
      sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/boot_cfg_bkpt_capture.sv
module boot_cfg_bkpt_capture
  import boot_cfg_bkpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pin_i,
  input  logic all_high_i,
  output logic synth_en_o,
  output logic dbg_mode_o
);
  logic mode_q;
  logic dbg_q;

  // Track the pins for the whole reset window; freeze on release.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= mode_pin_i;
      dbg_q  <= dbg_from_combined(all_high_i);
    end
  end

  assign synth_en_o = mode_q;
  assign dbg_mode_o = dbg_q;
endmodule

// File: rtl/boot_cfg_bkpt_route.sv
module boot_cfg_bkpt_route
  import boot_cfg_bkpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic all_high_i,
  input  logic dbg_mode_i,
  output logic fall_o,
  output logic dbg_req_o,
  output logic exc_req_o
);
  logic       prev_q;
  logic [1:0] req_d;
  logic       dbg_req_q;
  logic       exc_req_q;

  // Previous level also tracks during reset, so no false edge at release.
  always_ff @(posedge clk) begin
    prev_q <= all_high_i;
  end

  assign fall_o = prev_q & !all_high_i;
  assign req_d  = route_req(fall_o, dbg_mode_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_req_q <= 1'b0;
      exc_req_q <= 1'b0;
    end else begin
      dbg_req_q <= req_d[1];
      exc_req_q <= req_d[0];
    end
  end

  assign dbg_req_o = dbg_req_q;
  assign exc_req_o = exc_req_q;
endmodule

// File: rtl/boot_cfg_bkpt_port.sv
module boot_cfg_bkpt_port
  import boot_cfg_bkpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en_i,
  input  logic wr_sel_i,
  input  logic wr_data_i,
  input  logic rd_sel_i,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe_o,
  output logic rd_data_o
);
  logic data_q;
  logic dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (port_sel_e'(wr_sel_i) == PSEL_DIR) dir_q  <= wr_data_i;
      else                                   data_q <= wr_data_i;
    end
  end

  // Driver is cut the moment reset asserts, before any clock edge.
  assign pad_oe_o  = dir_q & rst_n;
  assign pad_o     = data_q;
  assign rd_data_o = (port_sel_e'(rd_sel_i) == PSEL_DIR) ? dir_q
                                                         : port_read(dir_q, data_q, pad_i);
endmodule

// File: rtl/boot_cfg_bkpt.sv
module boot_cfg_bkpt #(
  parameter int N_BKPT      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pin_i,
  output logic              mode_pin_o,
  output logic              mode_pin_oe_o,
  input  logic [N_BKPT-1:0] bkpt_n_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic              wr_data_i,
  input  logic              rd_sel_i,
  output logic              rd_data_o,
  output logic              synth_en_o,
  output logic              dbg_mode_o,
  output logic              dbg_req_o,
  output logic              exc_req_o
);
  logic [N_BKPT-1:0] bkpt_sync;
  logic              bkpt_all_high;
  logic              bkpt_fall;

  boot_cfg_bkpt_sync #(.W(N_BKPT), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (bkpt_n_i),
    .q_o (bkpt_sync)
  );

  assign bkpt_all_high = &bkpt_sync;

  boot_cfg_bkpt_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_pin_i (mode_pin_i),
    .all_high_i (bkpt_all_high),
    .synth_en_o (synth_en_o),
    .dbg_mode_o (dbg_mode_o)
  );

  boot_cfg_bkpt_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .all_high_i (bkpt_all_high),
    .dbg_mode_i (dbg_mode_o),
    .fall_o     (bkpt_fall),
    .dbg_req_o  (dbg_req_o),
    .exc_req_o  (exc_req_o)
  );

  boot_cfg_bkpt_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel_i),
    .pad_i     (mode_pin_i),
    .pad_o     (mode_pin_o),
    .pad_oe_o  (mode_pin_oe_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/boot_cfg_bkpt_chk.sv
module boot_cfg_bkpt_chk (
  input logic clk,
  input logic rst_n,
  input logic synth_en_o,
  input logic dbg_mode_o,
  input logic dbg_req_o,
  input logic exc_req_o,
  input logic bkpt_fall,
  input logic mode_pin_oe_o,
  input logic wr_en_i,
  input logic wr_sel_i,
  input logic wr_data_i
);
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(synth_en_o) && $stable(dbg_mode_o)));

  // R6
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_req_o && exc_req_o));

  // R6
  dbg_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_o |-> dbg_mode_o);

  // R6
  exc_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |-> !dbg_mode_o);

  // R5
  dbg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_o |=> !dbg_req_o);

  // R5
  exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_o |=> !exc_req_o);

  // R7
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_o || exc_req_o) |-> $past(bkpt_fall));

  // R10
  oe_reset_chk: assert property (@(posedge clk)
    !rst_n |-> !mode_pin_oe_o);

  // R8
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i && wr_data_i) |=> mode_pin_oe_o);
endmodule

bind boot_cfg_bkpt boot_cfg_bkpt_chk u_chk (.*);

// File: tb/tb_boot_cfg_bkpt.sv
module tb_boot_cfg_bkpt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_pin_i = 1'b1;
  logic [1:0] bkpt_n_i = 2'b11;
  logic       wr_en_i = 1'b0, wr_sel_i = 1'b0, wr_data_i = 1'b0, rd_sel_i = 1'b0;
  logic       mode_pin_o, mode_pin_oe_o, rd_data_o;
  logic       synth_en_o, dbg_mode_o, dbg_req_o, exc_req_o;

  int n_chk = 0;
  int n_fail = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  boot_cfg_bkpt dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Reference model: history of the ANDed breakpoint level per edge.
  int   hist[$] = '{1, 1, 1};   // [0]=edge-1, [1]=edge-2, [2]=edge-3
  logic m_mode = 1'b0, m_dbg = 1'b0, m_dreq = 1'b0, m_ereq = 1'b0;
  logic m_d = 1'b0, m_dir = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = mode_pin_i;
      m_dbg  = (hist[1] == 0);
      m_dreq = 1'b0;
      m_ereq = 1'b0;
      m_d    = 1'b0;
      m_dir  = 1'b0;
    end else begin
      m_dreq = (hist[2] == 1) && (hist[1] == 0) && m_dbg;
      m_ereq = (hist[2] == 1) && (hist[1] == 0) && !m_dbg;
      if (wr_en_i) begin
        if (wr_sel_i) m_dir = wr_data_i;
        else          m_d   = wr_data_i;
      end
    end
    void'(hist.pop_back());
    hist.push_front((&bkpt_n_i) ? 1 : 0);
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R1 synth_en", synth_en_o, m_mode);
      chk("R3/R4 dbg_mode", dbg_mode_o, m_dbg);
      chk("R6 dbg_req", dbg_req_o, m_dreq);
      chk("R6 exc_req", exc_req_o, m_ereq);
      chk("R10 oe", mode_pin_oe_o, rst_n & m_dir);
      chk("R8 pin_o", mode_pin_o, m_d);
      chk("R9 rd_data", rd_data_o, rd_sel_i ? m_dir : (m_dir ? m_d : mode_pin_i));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic count_pulses(input int n, output int nd, output int ne);
    nd = 0; ne = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (dbg_req_o) nd++;
      if (exc_req_o) ne++;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int nd, ne;
    // Scenario A: synthesizer clock, exception routing
    step(6);
    armed = 1'b1;
    rst_n = 1'b1;
    step(1);
    chk("R1 reset sample high", synth_en_o, 1'b1);
    chk("R4 both high", dbg_mode_o, 1'b0);
    chk("R10 input after reset", mode_pin_oe_o, 1'b0);
    mode_pin_i = 1'b0;
    step(3);
    chk("R2 mode held", synth_en_o, 1'b1);
    bkpt_n_i = 2'b10;                 // internal line falls; sampled at next edge k
    step(1); chk("R5 edge k", exc_req_o, 1'b0);
    step(1); chk("R5 edge k+1", exc_req_o, 1'b0);
    step(1); chk("R5 edge k+2", exc_req_o, 1'b1);
    step(1); chk("R5 edge k+3", exc_req_o, 1'b0);
    bkpt_n_i = 2'b00;                 // second line falls while first low
    count_pulses(5, nd, ne);
    chk("R7 no pulse while low", (nd + ne) == 0, 1'b1);
    bkpt_n_i = 2'b11;
    step(4);
    bkpt_n_i = 2'b01;                 // external line
    count_pulses(6, nd, ne);
    chk("R6 exc once", ne == 1, 1'b1);
    chk("R6 no dbg", nd == 0, 1'b1);
    bkpt_n_i = 2'b11;
    chk("R2 dbg held", dbg_mode_o, 1'b0);

    // Port bit
    mode_pin_i = 1'b1; rd_sel_i = 1'b0;
    step(1); chk("R9 read pin 1", rd_data_o, 1'b1);
    mode_pin_i = 1'b0;
    step(1); chk("R9 read pin 0", rd_data_o, 1'b0);
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 1'b1;
    step(1); wr_en_i = 1'b0;
    step(1);
    chk("R9 input ignores latch", rd_data_o, 1'b0);
    chk("R8 data drives pin_o", mode_pin_o, 1'b1);
    rd_sel_i = 1'b1;
    step(1); chk("R9 dir read 0", rd_data_o, 1'b0);
    wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 1'b1;
    step(1); wr_en_i = 1'b0;
    step(1);
    chk("R9 dir read 1", rd_data_o, 1'b1);
    chk("R10 oe on", mode_pin_oe_o, 1'b1);
    rd_sel_i = 1'b0;
    step(1); chk("R9 output reads latch", rd_data_o, 1'b1);

    // Scenario B: reset with external line low -> debug; writes in reset dropped
    rst_n = 1'b0;
    #2 chk("R10 oe off at once", mode_pin_oe_o, 1'b0);
    wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 1'b1;
    mode_pin_i = 1'b0;
    bkpt_n_i = 2'b01;
    step(5);
    rst_n = 1'b1; wr_en_i = 1'b0; rd_sel_i = 1'b1;
    step(1);
    chk("R1 reset sample low", synth_en_o, 1'b0);
    chk("R3 ext low", dbg_mode_o, 1'b1);
    chk("R11 dir write dropped", rd_data_o, 1'b0);
    count_pulses(3, nd, ne);
    chk("R7 no pulse at release", (nd + ne) == 0, 1'b1);
    bkpt_n_i = 2'b11;
    mode_pin_i = 1'b1;
    step(3);
    bkpt_n_i = 2'b10;
    count_pulses(6, nd, ne);
    chk("R6 dbg once", nd == 1, 1'b1);
    chk("R6 no exc", ne == 0, 1'b1);
    bkpt_n_i = 2'b11;
    step(2);
    chk("R2 dbg kept", dbg_mode_o, 1'b1);
    chk("R2 mode kept", synth_en_o, 1'b0);

    // Scenario C: internal line low at release, then both high
    rst_n = 1'b0; bkpt_n_i = 2'b10;
    step(5);
    rst_n = 1'b1;
    step(1); chk("R3 int low", dbg_mode_o, 1'b1);
    bkpt_n_i = 2'b11;
    step(2);
    rst_n = 1'b0;
    step(5);
    rst_n = 1'b1;
    step(1); chk("R4 both high again", dbg_mode_o, 1'b0);
    step(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule